// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

A 16-bit timer channel that generates two waveform outputs, A and B. A counter runs on every clock while enabled. It counts upward only or upward then downward, and the RC register can serve as the top value. Three compare registers, a software trigger and one selectable external event can each set, clear or toggle an output, or leave it unchanged. Each event source carries its own action code for each output.

Software drives the block through single-cycle write and read strobes. Writes load the action fields, the mode word, the compare values, the interrupt mask and the command strobes. Reads return the configuration, the compare values, the live count and the sticky event flags. When RC compares, the block can optionally halt the counter (until the next trigger) or turn it off (until it is enabled again). A masked flag raises the interrupt line.

Top module: `wave_timer`

## Requirements
- R1: After reset both outputs, the counter, the flags and `irq` are zero, and every action field reads as no-op.
- R2: An action code is 0 = no-op, 1 = set, 2 = clear, 3 = toggle. Output A takes its codes from write address 0: bits [1:0] for RA compare, [3:2] for RC compare, [5:4] for the external event and [7:6] for the software trigger. Output B takes its codes from address 1 in the same layout, with RB compare in bits [1:0].
- R3: A compare with RA, RB or RC fires on the clock edge that ends a cycle in which the counter is running and equals that register. The output reacts and the flag is set on that same edge.
- R4: Mode word (address 2) bits [1:0] select the waveform. 0 counts up and wraps from 0xFFFF to 0, setting the overflow flag (bit 0). 1 counts up and returns to 0 on the step after RC compare. 2 counts up to 0xFFFF and back down to 0, setting the overflow flag at the turn. 3 counts up to RC and back down to 0.
- R5: In modes 2 and 3 the count reverses at the top value and reverses again at zero, so it passes through each value once on the way up and once on the way down.
- R6: With mode bit 7 set, RC compare halts the counter after that step. It stays halted, with its value frozen, until a trigger.
- R7: With mode bit 8 set, RC compare clears the counter enable. A later trigger zeroes the counter but does not restart it until an enable command arrives.
- R8: A write to address 6 is a command: bit 0 enables the counter, bit 1 disables it (disable wins), and bit 2 is a software trigger. The trigger zeroes the counter, restores upward counting and releases a halt.
- R9: Mode bits [3:2] pick the event source: 0 for the B-side input `pin_b_in`, and 1, 2, 3 for `ext_line[0]`, `[1]`, `[2]`. Mode bits [5:4] pick the active edge: 0 none, 1 rising, 2 falling, 3 both. Edges on the other sources are ignored.
- R10: With mode bit 6 set, each external event also acts as a trigger (as in R8) and sets the external-trigger flag (bit 7).
- R11: If several events hit an output in the same cycle, the one that acts is the first non-no-op code in this order: software trigger, external event, RC compare, RA/RB compare.
- R12: The flags are overflow (bit 0), RA compare (2), RB compare (3), RC compare (4) and external trigger (7). Reading address 7 returns them and clears them, but an event on the same edge is kept. Read addresses 3, 4, 5 and 6 return RA, RB, RC and the counter. A write to address 7 loads the interrupt mask, and `irq` is high while any flag is set under the mask. Read data appears the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| pin_b_in | input | 1 | B-side event input |
| ext_line | input | 3 | Auxiliary event lines |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| irq | output | 1 | Masked flag interrupt |

## Verification
The bench targets the exact compare edge. A design that is one cycle off moves output A one sample early or late. It also separates halt from disable after RC: if the two are confused, a plain trigger restarts a counter that should stay idle, or leaves a halted one frozen. The up/down turn is frozen mid-descent and read back; a design that does not reverse returns 8 instead of 2. Further cases:
- A trigger and an external event arrive on the same edge with conflicting codes; wrong priority gives the wrong level on A.
- An edge arrives on an unselected line and must not move A.
- Flags are read twice in a row; a design that does not clear them on read returns a nonzero second value.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    WV_UP    = 2'd0,
    WV_UP_RC = 2'd1,
    WV_UD    = 2'd2,
    WV_UD_RC = 2'd3
  } wave_e;

  // mode word, MSB first
  typedef struct packed {
    logic       dis_rc;
    logic       stop_rc;
    logic       ev_trig;
    logic [1:0] edge_sel;
    logic [1:0] src_sel;
    wave_e      wave;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int NSRC   = 4;   // event sources per output
  localparam int FLAG_W = 8;

  localparam logic [2:0] AD_ACT_A = 3'd0;
  localparam logic [2:0] AD_ACT_B = 3'd1;
  localparam logic [2:0] AD_MODE  = 3'd2;
  localparam logic [2:0] AD_CMPA  = 3'd3;
  localparam logic [2:0] AD_CMPB  = 3'd4;
  localparam logic [2:0] AD_TOP   = 3'd5;
  localparam logic [2:0] AD_CMD   = 3'd6;   // write: command, read: counter
  localparam logic [2:0] AD_FLAG  = 3'd7;   // write: mask, read: flags

  localparam int FB_OVF  = 0;
  localparam int FB_CMPA = 2;
  localparam int FB_CMPB = 3;
  localparam int FB_TOP  = 4;
  localparam int FB_ETRG = 7;

endpackage

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_set,
  input  logic         en_clr,
  input  logic         trig,
  input  wave_e        wave,
  input  logic [W-1:0] top_val,
  input  logic         stop_rc,
  input  logic         dis_rc,
  output logic [W-1:0] cnt,
  output logic         tick,
  output logic         rc_hit,
  output logic         ovf
);

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         clken_q, clken_d;
  logic         halt_q, halt_d;
  logic         down_q, down_d;
  logic [W-1:0] cnt_d, turn;

  always_comb begin
    tick   = clken_q & ~halt_q;
    rc_hit = tick & (cnt == top_val);
    turn   = (wave == WV_UD_RC) ? top_val : ALL1;
    cnt_d  = cnt;
    down_d = down_q;
    ovf    = 1'b0;
    if (tick) begin
      unique case (wave)
        WV_UP: begin
          ovf   = (cnt == ALL1);
          cnt_d = cnt + 1'b1;
        end
        WV_UP_RC: begin
          if (cnt == top_val) begin
            cnt_d = '0;
          end else begin
            ovf   = (cnt == ALL1);
            cnt_d = cnt + 1'b1;
          end
        end
        default: begin
          if (!down_q) begin
            if (cnt == turn) begin
              down_d = 1'b1;
              ovf    = (wave == WV_UD);
              cnt_d  = (cnt == '0) ? cnt : cnt - 1'b1;
            end else begin
              cnt_d = cnt + 1'b1;
            end
          end else begin
            if (cnt == '0) begin
              down_d = 1'b0;
              cnt_d  = (turn == '0) ? cnt : cnt + 1'b1;
            end else begin
              cnt_d = cnt - 1'b1;
            end
          end
        end
      endcase
    end
    if (trig) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end

    clken_d = clken_q;
    if (en_set) clken_d = 1'b1;
    if (rc_hit && dis_rc) clken_d = 1'b0;
    if (en_clr) clken_d = 1'b0;

    halt_d = halt_q;
    if (rc_hit && stop_rc) halt_d = 1'b1;
    if (trig) halt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      clken_q <= 1'b0;
      halt_q  <= 1'b0;
      down_q  <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      clken_q <= clken_d;
      halt_q  <= halt_d;
      down_q  <= down_d;
    end
  end

  a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !trig) |=> $stable(cnt));

  a_r7_off_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_q && !trig) |=> $stable(cnt));

endmodule

// File: rtl/wt_evdet.sv
module wt_evdet
  import wt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [1:0]      src_sel,
  input  logic [1:0]      edge_sel,
  output logic            evt
);

  logic [NSRC-1:0] prev_q;
  logic            cur, old;

  always_comb begin
    cur = src[src_sel];
    old = prev_q[src_sel];
    unique case (edge_sel)
      2'd0:    evt = 1'b0;
      2'd1:    evt = cur & ~old;
      2'd2:    evt = ~cur & old;
      default: evt = cur ^ old;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  a_r9_no_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'd0) |-> !evt);

endmodule

// File: rtl/wt_pin.sv
module wt_pin
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hit,   // index 0 has the highest priority
  input  logic [2*NSRC-1:0] act,
  output logic              pin
);

  act_e won;
  logic pin_d;

  always_comb begin
    won = ACT_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i] && (act[2*i +: 2] != 2'd0)) won = act_e'(act[2*i +: 2]);
    end
    unique case (won)
      ACT_SET: pin_d = 1'b1;
      ACT_CLR: pin_d = 1'b0;
      ACT_TOG: pin_d = ~pin;
      default: pin_d = pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end

  a_r11_sw_set_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && act[1:0] == 2'd1) |=> pin);

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         pin_b_in,
  input  logic [2:0]   ext_line,
  output logic         out_a,
  output logic         out_b,
  output logic         irq
);

  localparam int NPIN = 2;
  localparam int AW   = 2 * NSRC;

  logic [AW-1:0]     act_a_q, act_a_d, act_b_q, act_b_d;
  mode_t             mode_q, mode_d;
  logic [W-1:0]      cmpa_q, cmpa_d, cmpb_q, cmpb_d, top_q, top_d;
  logic [FLAG_W-1:0] mask_q, mask_d, flag_q, flag_d, flag_set;
  logic [W-1:0]      rd_d;

  logic         wr_cmd, en_set, en_clr, sw_trig, trig;
  logic [W-1:0] cnt;
  logic         tick, rc_hit, ovf, evt, hit_a, hit_b;
  logic [NPIN-1:0]           pins;
  logic [NPIN-1:0]           cmp_hit;
  logic [NPIN-1:0][AW-1:0]   pin_act;
  logic [NPIN-1:0][AW-1:0]   pin_reg;

  // command strobes
  always_comb begin
    wr_cmd  = wr_en && (wr_addr == AD_CMD);
    en_set  = wr_cmd && wr_data[0];
    en_clr  = wr_cmd && wr_data[1];
    sw_trig = wr_cmd && wr_data[2];
    trig    = sw_trig || (evt && mode_q.ev_trig);
  end

  wt_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .trig    (trig),
    .wave    (mode_q.wave),
    .top_val (top_q),
    .stop_rc (mode_q.stop_rc),
    .dis_rc  (mode_q.dis_rc),
    .cnt     (cnt),
    .tick    (tick),
    .rc_hit  (rc_hit),
    .ovf     (ovf)
  );

  wt_evdet u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      ({ext_line, pin_b_in}),
    .src_sel  (mode_q.src_sel),
    .edge_sel (mode_q.edge_sel),
    .evt      (evt)
  );

  always_comb begin
    hit_a      = tick && (cnt == cmpa_q);
    hit_b      = tick && (cnt == cmpb_q);
    cmp_hit    = {hit_b, hit_a};
    pin_reg[0] = act_a_q;
    pin_reg[1] = act_b_q;
  end

  // per output: reorder register fields into priority order sw, evt, rc, cmp
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pin_act[g] = {pin_reg[g][1:0], pin_reg[g][3:2],
                         pin_reg[g][5:4], pin_reg[g][7:6]};
    wt_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   ({cmp_hit[g], rc_hit, evt, sw_trig}),
      .act   (pin_act[g]),
      .pin   (pins[g])
    );
  end

  assign out_a = pins[0];
  assign out_b = pins[1];
  assign irq   = |(flag_q & mask_q);

  // register next state
  always_comb begin
    act_a_d = act_a_q;
    act_b_d = act_b_q;
    mode_d  = mode_q;
    cmpa_d  = cmpa_q;
    cmpb_d  = cmpb_q;
    top_d   = top_q;
    mask_d  = mask_q;
    if (wr_en) begin
      unique case (wr_addr)
        AD_ACT_A: act_a_d = wr_data[AW-1:0];
        AD_ACT_B: act_b_d = wr_data[AW-1:0];
        AD_MODE:  mode_d  = mode_t'(wr_data[MODE_W-1:0]);
        AD_CMPA:  cmpa_d  = wr_data;
        AD_CMPB:  cmpb_d  = wr_data;
        AD_TOP:   top_d   = wr_data;
        AD_FLAG:  mask_d  = wr_data[FLAG_W-1:0];
        default: ;
      endcase
    end

    flag_set          = '0;
    flag_set[FB_OVF]  = ovf;
    flag_set[FB_CMPA] = hit_a;
    flag_set[FB_CMPB] = hit_b;
    flag_set[FB_TOP]  = rc_hit;
    flag_set[FB_ETRG] = evt && mode_q.ev_trig;
    if (rd_en && rd_addr == AD_FLAG) flag_d = flag_set;
    else                             flag_d = flag_q | flag_set;

    unique case (rd_addr)
      AD_ACT_A: rd_d = W'(act_a_q);
      AD_ACT_B: rd_d = W'(act_b_q);
      AD_MODE:  rd_d = W'(mode_q);
      AD_CMPA:  rd_d = cmpa_q;
      AD_CMPB:  rd_d = cmpb_q;
      AD_TOP:   rd_d = top_q;
      AD_CMD:   rd_d = cnt;
      default:  rd_d = W'(flag_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q <= '0;
      act_b_q <= '0;
      mode_q  <= '0;
      cmpa_q  <= '0;
      cmpb_q  <= '0;
      top_q   <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
      rd_data <= '0;
    end else begin
      act_a_q <= act_a_d;
      act_b_q <= act_b_d;
      mode_q  <= mode_d;
      cmpa_q  <= cmpa_d;
      cmpb_q  <= cmpb_d;
      top_q   <= top_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      if (rd_en) rd_data <= rd_d;
    end
  end

  a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AD_FLAG && flag_set == '0) |=> (flag_q == '0));

  a_r3_top_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rc_hit |=> flag_q[FB_TOP]);

endmodule

// File: tb/sim_wave_timer.sv
module sim_wave_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        pin_b_in;
  logic [2:0]  ext_line;
  logic        out_a, out_b, irq;

  always #5 clk = ~clk;

  wave_timer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pin_b_in (pin_b_in),
    .ext_line (ext_line),
    .out_a    (out_a),
    .out_b    (out_b),
    .irq      (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // scoreboard of expected read data
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read data 0x%04h with nothing expected", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: read got 0x%04h expected 0x%04h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    pin_b_in = 1'b0; ext_line = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 out_a", out_a, 1'b0);
    chk("R1 out_b", out_b, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rd(3'd6, 16'h0000, "R1 counter");
    rd(3'd7, 16'h0000, "R1 flags");
    rd(3'd0, 16'h0000, "R1 action A");

    // R2 R3 R4 R6: up with RC reset, RA sets A, RC clears A, halt at RC
    wr(3'd3, 16'd3);
    wr(3'd5, 16'd10);
    wr(3'd0, 16'h0009);
    wr(3'd2, 16'h0081);
    wr(3'd6, 16'h0005);
    idle(6);
    chk("R2 RA compare sets A", out_a, 1'b1);
    idle(20);
    chk("R2 RC compare clears A", out_a, 1'b0);
    rd(3'd6, 16'd0, "R4 mode1 back to zero, R6 halted");
    rd(3'd7, 16'h001C, "R12 compare flags");
    rd(3'd7, 16'h0000, "R12 cleared by read");

    // R6 R3: plain trigger restarts a halted counter; exact compare edge
    wr(3'd6, 16'h0004);
    idle(3);
    chk("R3 A before compare edge", out_a, 1'b0);
    idle(1);
    chk("R3 A on compare edge", out_a, 1'b1);
    idle(20);
    rd(3'd7, 16'h001C, "R6 restarted run flags");

    // R7: disable at RC, trigger alone does not restart
    wr(3'd2, 16'h0100);
    wr(3'd6, 16'h0004);
    idle(20);
    rd(3'd6, 16'd11, "R7 frozen after RC step");
    chk("R2 A cleared by RC", out_a, 1'b0);
    rd(3'd7, 16'h001C, "R7 flags");
    wr(3'd6, 16'h0004);
    idle(5);
    rd(3'd6, 16'd0, "R7 trigger zeroes but stays off");
    rd(3'd7, 16'h0000, "R7 no flags while off");

    // R4 overflow in mode 0, R8 enable/disable
    wr(3'd2, 16'h0000);
    wr(3'd6, 16'h0005);
    idle(65545);
    wr(3'd6, 16'h0002);
    rd(3'd7, 16'h001D, "R4 overflow flag");
    rd(3'd6, 16'd10, "R8 count stops after disable");
    chk("R2 A set by last RA", out_a, 1'b1);

    // R5: up/down to RC, frozen while descending; RB toggles B
    wr(3'd2, 16'h0003);
    wr(3'd5, 16'd5);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'h0003);
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h0005);
    idle(7);
    wr(3'd6, 16'h0002);
    rd(3'd6, 16'd2, "R5 count reversed at RC");
    chk("R2 RB toggles B", out_b, 1'b1);
    rd(3'd7, 16'h001C, "R5 flags without overflow");

    // R9 R10: event source ext_line[1], rising, triggering, toggles A
    wr(3'd0, 16'h0030);
    wr(3'd2, 16'h0058);
    ext_line[0] = 1'b1;
    idle(1);
    chk("R9 unselected line ignored", out_a, 1'b1);
    ext_line[1] = 1'b1;
    idle(1);
    chk("R9 rising edge toggles A", out_a, 1'b0);
    rd(3'd6, 16'd0, "R10 event trigger zeroes counter");
    rd(3'd7, 16'h0080, "R10 ext trigger flag");
    ext_line[1] = 1'b0;
    idle(1);
    chk("R9 falling edge ignored in rising mode", out_a, 1'b0);
    wr(3'd2, 16'h0078);
    ext_line[1] = 1'b1;
    idle(1);
    chk("R9 both edges rise", out_a, 1'b1);
    ext_line[1] = 1'b0;
    idle(1);
    chk("R9 both edges fall", out_a, 1'b0);
    wr(3'd2, 16'h0070);
    pin_b_in = 1'b1;
    idle(1);
    chk("R9 B input source", out_a, 1'b1);

    // R11 R12: priority and interrupt
    wr(3'd7, 16'h0080);
    rd(3'd7, 16'h0080, "R12 flags before priority");
    chk("R12 irq low after clear", irq, 1'b0);
    wr(3'd0, 16'h0060);
    wr(3'd2, 16'h0058);
    ext_line[1] = 1'b1;
    wr(3'd6, 16'h0004);
    chk("R11 software trigger beats event", out_a, 1'b1);
    chk("R12 irq on masked flag", irq, 1'b1);
    ext_line[1] = 1'b0;
    idle(1);
    ext_line[1] = 1'b1;
    idle(1);
    chk("R11 event alone clears A", out_a, 1'b0);
    rd(3'd7, 16'h0080, "R12 ext flag");
    chk("R12 irq drops after read", irq, 1'b0);

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d reads unanswered", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule